// File: doc/BRIEF.md
# I2C Transfer Length Counter with Reload

This block tracks how many bytes remain in an I2C transfer. Software loads an 8-bit count, and the count drops by one on each byte-complete pulse, which the bus engine gives at the acknowledge clock. In controller (master) mode the counter always runs. In target (slave) mode it runs only when a separate counting-enable bit is set.

Transfers of more than 255 bytes, and receivers that want to decide the acknowledge value of a given byte, use reload mode. When the count runs out with reload set, a reload-pending flag rises and the block asks the bus engine to hold SCL low. Both stay in place until software writes a new non-zero count. The last chunk is loaded with reload cleared. When that chunk runs out in controller mode, a transfer-done indication goes to the logic that issues NACK, STOP or repeated START. This block does not generate those bus conditions.

Top module: `i2c_xfer_len_ctr`

## Requirements
- R1: After a synchronous active-high reset, `count_o`, `reload_pend_o`, `xfer_done_o`, `hold_scl_o` and `irq_o` are all 0.
- R2: A cycle with `len_wr`=1 loads `len_wdata` into `count_o` and `reload_in` into the internal reload bit at the next edge. A byte pulse in the same cycle is not counted.
- R3: While counting is active, each `byte_done` pulse lowers `count_o` by one. At zero the count stays at zero and never wraps.
- R4: Counting is active when `ctrl_mode`=1 (controller), or when `ctrl_mode`=0 and `tgt_cnt_en`=1. Otherwise `byte_done` leaves `count_o` and the flags unchanged.
- R5: A counted byte that takes `count_o` from 1 to 0 while the reload bit is 1 sets `reload_pend_o` at that edge. `hold_scl_o` equals `reload_pend_o` on every cycle.
- R6: `irq_o` is registered: at each edge it takes the new `reload_pend_o` value ANDed with `pend_ie` as sampled in the preceding cycle.
- R7: A write with non-zero `len_wdata` clears `reload_pend_o` at that edge. A write of zero leaves the flag set, and the flag otherwise holds.
- R8: A counted byte that takes `count_o` from 1 to 0 with the reload bit 0 and `ctrl_mode`=1 sets `xfer_done_o`. Any `len_wr` clears it. `xfer_done_o` and `reload_pend_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_mode | input | 1 | 1 = controller mode, 0 = target mode |
| tgt_cnt_en | input | 1 | Enables counting in target mode |
| pend_ie | input | 1 | Interrupt enable for the reload-pending flag |
| len_wr | input | 1 | Write strobe for count and reload bit |
| len_wdata | input | CNT_W | Count value to load |
| reload_in | input | 1 | Reload bit written with the count |
| byte_done | input | 1 | One-cycle pulse per completed byte (acknowledge clock) |
| count_o | output | CNT_W | Remaining byte count |
| reload_pend_o | output | 1 | Count exhausted in reload mode, waiting for a new count |
| xfer_done_o | output | 1 | Final chunk finished in controller mode |
| hold_scl_o | output | 1 | Request to stretch SCL low |
| irq_o | output | 1 | Interrupt for the reload-pending flag |

## Verification
On every cycle, the assertions check these properties:
- the count never wraps;
- the count stays still when counting is inactive;
- the SCL hold request matches the reload-pending flag;
- the flag holds until a non-zero write, and that write clears it;
- the two completion flags are never raised together.

Only the bench's scenarios show the following behaviour:
- the exact count sequence;
- that a write wins over a same-cycle byte pulse;
- the one-cycle interrupt lag behind the enable;
- the difference between controller and target mode when a chunk without reload runs out.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int unsigned CNT_W_DEF = 8;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_LOAD = 2'd1,
    EV_DEC  = 2'd2
  } cnt_ev_e;

  typedef struct packed {
    logic reload;
    logic pend;
    logic done;
  } flag_s;
endpackage

// File: rtl/xlc_counter.sv
module xlc_counter import xlc_pkg::*; #(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             byte_done,
  input  logic             active,
  output logic [CNT_W-1:0] count_q,
  output logic             last_byte
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  cnt_ev_e ev;

  always_comb begin
    if (wr)
      ev = EV_LOAD;
    else if (byte_done && active && count_q != ZERO)
      ev = EV_DEC;
    else
      ev = EV_NONE;
  end

  assign last_byte = (ev == EV_DEC) && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)
      count_q <= ZERO;
    else begin
      case (ev)
        EV_LOAD: count_q <= wdata;
        EV_DEC:  count_q <= count_q - ONE;
        default: count_q <= count_q;
      endcase
    end
  end

  // R3: no wrap below zero
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (count_q == ZERO && !wr) |=> (count_q == ZERO));

  // R4: inactive counter holds
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!active && !wr) |=> $stable(count_q));
endmodule

// File: rtl/xlc_flags.sv
module xlc_flags import xlc_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr,
  input  logic  wdata_nz,
  input  logic  reload_in,
  input  logic  last_byte,
  input  logic  ctrl_mode,
  output flag_s flags_q,
  output logic  pend_next
);
  flag_s nxt;

  always_comb begin
    nxt = flags_q;
    if (wr) begin
      nxt.reload = reload_in;
      nxt.done   = 1'b0;
      if (wdata_nz)
        nxt.pend = 1'b0;
    end else if (last_byte) begin
      if (flags_q.reload)
        nxt.pend = 1'b1;
      else if (ctrl_mode)
        nxt.done = 1'b1;
    end
  end

  assign pend_next = nxt.pend;

  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= '0;
    else
      flags_q <= nxt;
  end

  // R7: flag holds until a non-zero count write
  p_pend_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (flags_q.pend && !(wr && wdata_nz)) |=> flags_q.pend);

  // R7: non-zero write clears the flag
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata_nz) |=> !flags_q.pend);

  // R8: completion flags exclusive
  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(flags_q.pend && flags_q.done));
endmodule

// File: rtl/xlc_outputs.sv
module xlc_outputs (
  input  logic clk,
  input  logic rst,
  input  logic pend_next,
  input  logic pend_ie,
  output logic hold_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      hold_q <= pend_next;
      irq_q  <= pend_next & pend_ie;
    end
  end

  // R6: interrupt only while a hold is requested
  p_irq_needs_hold_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> hold_q);
endmodule

// File: rtl/i2c_xfer_len_ctr.sv
module i2c_xfer_len_ctr import xlc_pkg::*; #(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_mode,
  input  logic             tgt_cnt_en,
  input  logic             pend_ie,
  input  logic             len_wr,
  input  logic [CNT_W-1:0] len_wdata,
  input  logic             reload_in,
  input  logic             byte_done,
  output logic [CNT_W-1:0] count_o,
  output logic             reload_pend_o,
  output logic             xfer_done_o,
  output logic             hold_scl_o,
  output logic             irq_o
);
  logic  active;
  logic  last_byte;
  logic  pend_next;
  flag_s flags;

  assign active = ctrl_mode | tgt_cnt_en;

  xlc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .wr        (len_wr),
    .wdata     (len_wdata),
    .byte_done (byte_done),
    .active    (active),
    .count_q   (count_o),
    .last_byte (last_byte)
  );

  xlc_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .wr        (len_wr),
    .wdata_nz  (|len_wdata),
    .reload_in (reload_in),
    .last_byte (last_byte),
    .ctrl_mode (ctrl_mode),
    .flags_q   (flags),
    .pend_next (pend_next)
  );

  xlc_outputs u_out (
    .clk       (clk),
    .rst       (rst),
    .pend_next (pend_next),
    .pend_ie   (pend_ie),
    .hold_q    (hold_scl_o),
    .irq_q     (irq_o)
  );

  assign reload_pend_o = flags.pend;
  assign xfer_done_o   = flags.done;

  // R5: SCL hold mirrors the reload-pending flag
  p_hold_tracks_r5: assert property (@(posedge clk) disable iff (rst)
    hold_scl_o == reload_pend_o);
endmodule

// File: tb/test_i2c_xfer_len_ctr.sv
module test_i2c_xfer_len_ctr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_mode = 1'b0, tgt_cnt_en = 1'b0, pend_ie = 1'b0;
  logic len_wr = 1'b0, reload_in = 1'b0, byte_done = 1'b0;
  logic [W-1:0] len_wdata = '0;
  logic [W-1:0] count_o;
  logic reload_pend_o, xfer_done_o, hold_scl_o, irq_o;

  always #5 clk = ~clk;

  i2c_xfer_len_ctr #(.CNT_W(W)) i_i2c_xfer_len_ctr (
    .clk(clk), .rst(rst), .ctrl_mode(ctrl_mode), .tgt_cnt_en(tgt_cnt_en),
    .pend_ie(pend_ie), .len_wr(len_wr), .len_wdata(len_wdata),
    .reload_in(reload_in), .byte_done(byte_done), .count_o(count_o),
    .reload_pend_o(reload_pend_o), .xfer_done_o(xfer_done_o),
    .hold_scl_o(hold_scl_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [W-1:0] cnt;
    logic pend, done, irq;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  // monitor: compares after each active edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (count_o !== e.cnt || reload_pend_o !== e.pend || xfer_done_o !== e.done ||
            hold_scl_o !== e.pend || irq_o !== e.irq) begin
          errors++;
          $display("FAIL %s: got cnt=%0d pend=%b done=%b hold=%b irq=%b exp cnt=%0d pend=%b done=%b hold=%b irq=%b",
                   e.tag, count_o, reload_pend_o, xfer_done_o, hold_scl_o, irq_o,
                   e.cnt, e.pend, e.done, e.pend, e.irq);
        end
      end
    end
  end

  task automatic step(input logic wr, input int data, input logic rel, input logic bd,
                      input logic cm, input logic te, input logic ie,
                      input int ecnt, input logic ep, input logic ed, input logic ei,
                      input string tag);
    exp_t e;
    @(negedge clk);
    len_wr = wr; len_wdata = W'(data); reload_in = rel; byte_done = bd;
    ctrl_mode = cm; tgt_cnt_en = te; pend_ie = ie;
    e.cnt = W'(ecnt); e.pend = ep; e.done = ed; e.irq = ei; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    step(0,0,0,0, 1,0,0, 0,0,0,0, "R1");
    // controller mode, no reload
    step(1,3,0,0, 1,0,0, 3,0,0,0, "R2");
    step(0,0,0,1, 1,0,0, 2,0,0,0, "R3");
    step(0,0,0,1, 1,0,0, 1,0,0,0, "R3");
    step(0,0,0,1, 1,0,0, 0,0,1,0, "R8");
    step(0,0,0,1, 1,0,0, 0,0,1,0, "R3");
    // reload chunk
    step(1,2,1,0, 1,0,0, 2,0,0,0, "R8");
    step(0,0,0,1, 1,0,0, 1,0,0,0, "R3");
    step(0,0,0,1, 1,0,0, 0,1,0,0, "R5");
    step(0,0,0,0, 1,0,1, 0,1,0,1, "R6");
    step(1,0,1,0, 1,0,1, 0,1,0,1, "R7");
    step(0,0,0,1, 1,0,1, 0,1,0,1, "R3");
    step(0,0,0,0, 1,0,0, 0,1,0,0, "R6");
    step(1,2,0,0, 1,0,1, 2,0,0,0, "R7");
    step(1,5,0,1, 1,0,0, 5,0,0,0, "R2");
    step(0,0,0,1, 1,0,0, 4,0,0,0, "R3");
    // target mode
    step(0,0,0,1, 0,0,0, 4,0,0,0, "R4");
    step(0,0,0,1, 0,0,0, 4,0,0,0, "R4");
    step(0,0,0,1, 0,1,0, 3,0,0,0, "R4");
    step(1,1,0,0, 0,1,0, 1,0,0,0, "R2");
    step(0,0,0,1, 0,1,0, 0,0,0,0, "R8");
    step(1,1,1,0, 0,1,0, 1,0,0,0, "R2");
    step(0,0,0,1, 0,1,1, 0,1,0,1, "R5");
    step(0,0,0,1, 0,0,1, 0,1,0,1, "R4");
    step(1,9,0,0, 0,0,0, 9,0,0,0, "R7");
    step(0,0,0,0, 0,0,0, 9,0,0,0, "R4");
    @(negedge clk);
    len_wr = 0; byte_done = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule